// File: doc/BRIEF.md
# Configuration Access Address Generator

This block turns one configuration-space request into accesses on a single 32-bit memory port. A request names a bus, a device, a function, a 12-bit register offset, an access size, and whether it is a read or a write. Requests for bus 0 go to the register window of a root port. The device number picks the port: device N selects port N−1. Requests for every other bus go into one shared configuration aperture. Bus, device, function and register number are packed into the aperture offset.

Reads of one or two bytes fetch the whole aligned word and return the selected lane, right-justified. Writes of one or two bytes are done as a read, a lane merge and a write-back. Only one memory operation is in flight at a time. The front side takes no new request until the current one has produced its response, and that includes the write-back of a merge.

Each root port has an enable bit and a base address. Both come from configuration registers outside this block, as does the aperture base.

Top module: `cfg_addr_gen`

## Requirements
- R1: On bus 0, device N (1 ≤ N ≤ NUM_PORTS) with port N−1 enabled accesses address port_base[N−1] + (reg with bits [1:0] forced to zero). The function number is ignored.
- R2: On bus 0, device 0, a device above NUM_PORTS, or a disabled port gives status 1 (not found), with no memory access. The response comes the cycle after acceptance. Read data is 0xFFFFFFFF for a read and 0 for a write.
- R3: On any bus other than 0, the address is apt_base + offset. The offset is built as: reg[11:8] at bits [27:24], bus at [23:16], device at [15:11], function at [10:8], and reg[7:2] at [7:2], with bits [1:0] zero.
- R4: Read data for size 1 is (word >> 8·reg[1:0]) & 0xFF. For size 2 it is (word >> 8·reg[1:0]) & 0xFFFF. Every other read size returns the full word.
- R5: A size-4 write is a single memory write of req_wdata to the formed address.
- R6: A size-1 or size-2 write reads the word, then writes it back. In the written word the target lane is replaced by req_wdata masked to the lane width and shifted left by 8·reg[1:0]. All other bits are kept.
- R7: A write whose size is not 1, 2 or 4 to an existing target gives status 2 (bad register), with no memory access. A missing target still reports status 1.
- R8: req_ready is low from the acceptance of a request that touches memory until the cycle its response is given. At most one memory operation is outstanding, and mem_valid is a one-cycle pulse.
- R9: After reset, req_ready is 1, and mem_valid and rsp_valid are 0.
- R10: A completed access reports status 0. A completed write returns read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| port_en | input | NUM_PORTS | Enable bit per root port |
| port_base | input | NUM_PORTS*ADDR_W | Register window base per root port, port 0 in the low bits |
| apt_base | input | ADDR_W | Base of the configuration aperture for buses other than 0 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 for write, 0 for read |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device (slot) number |
| req_fn | input | 3 | Function number |
| req_reg | input | 12 | Register byte offset |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write value, right-justified |
| rsp_valid | output | 1 | Response pulse |
| rsp_status | output | 2 | 0 ok, 1 not found, 2 bad register |
| rsp_rdata | output | 32 | Read result |
| mem_valid | output | 1 | Memory operation pulse |
| mem_write | output | 1 | Memory operation is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 32 | Memory write word |
| mem_rsp_valid | input | 1 | Memory operation complete |
| mem_rdata | input | 32 | Memory read word, valid with mem_rsp_valid |

## Verification
The bench uses register offsets with bits set in [11:8], so a design that drops the extended register bits, or puts them in the wrong place, sends the access to a wrong address. It reads from every byte lane, including a halfword in the top lane. A wrong shift amount shows up as wrong read data. It also writes bytes with a value wider than the lane, so a merge that forgets to mask the value corrupts the neighbouring byte in the written word. Three cases should cause no memory traffic: a disabled port, device 0, and a write of size 0, 3 or 5. A design that still touched memory in any of these would be seen issuing an unexpected memory operation. The bench also samples req_ready right after acceptance, which catches a design that takes a new request before its merge write-back has finished.

// File: rtl/cfg_addr_gen.sv
module cfg_addr_gen #(
  parameter int ADDR_W    = 32,
  parameter int NUM_PORTS = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_PORTS-1:0]          port_en,
  input  logic [NUM_PORTS*ADDR_W-1:0]   port_base,
  input  logic [ADDR_W-1:0]             apt_base,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [7:0]                    req_bus,
  input  logic [4:0]                    req_dev,
  input  logic [2:0]                    req_fn,
  input  logic [11:0]                   req_reg,
  input  logic [2:0]                    req_size,
  input  logic [31:0]                   req_wdata,
  output logic                          rsp_valid,
  output logic [1:0]                    rsp_status,
  output logic [31:0]                   rsp_rdata,
  output logic                          mem_valid,
  output logic                          mem_write,
  output logic [ADDR_W-1:0]             mem_addr,
  output logic [31:0]                   mem_wdata,
  input  logic                          mem_rsp_valid,
  input  logic [31:0]                   mem_rdata
);

  localparam logic [1:0] ST_OK     = 2'd0;
  localparam logic [1:0] ST_NODEV  = 2'd1;
  localparam logic [1:0] ST_BADREG = 2'd2;
  localparam int         OFS_W     = 28;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_RMW, S_WR} state_t;
  state_t state;

  logic              hit;
  logic [ADDR_W-1:0] port_addr;

  always_comb begin
    hit       = 1'b0;
    port_addr = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (req_dev == 5'(p + 1) && port_en[p]) begin
        hit       = 1'b1;
        port_addr = port_base[p*ADDR_W +: ADDR_W] + ADDR_W'({req_reg[11:2], 2'b00});
      end
    end
  end

  logic [OFS_W-1:0] apt_ofs;
  assign apt_ofs = {req_reg[11:8], req_bus, req_dev, req_fn, req_reg[7:2], 2'b00};

  logic bus0, found, sub, size_ok, accept;
  logic [ADDR_W-1:0] tgt_addr;
  assign bus0     = (req_bus == 8'd0);
  assign found    = !bus0 || hit;
  assign tgt_addr = bus0 ? port_addr : apt_base + ADDR_W'(apt_ofs);
  assign sub      = (req_size == 3'd1) || (req_size == 3'd2);
  assign size_ok  = sub || (req_size == 3'd4);
  assign req_ready = (state == S_IDLE);
  assign accept    = req_valid && req_ready;

  logic [1:0]  lane_q;
  logic        half_q, sub_q;
  logic [31:0] wdata_q;

  logic [4:0]  sh;
  logic [31:0] msk, rd_lane, merged;
  assign sh      = {lane_q, 3'b000};
  assign msk     = half_q ? 32'h0000_FFFF : 32'h0000_00FF;
  assign rd_lane = sub_q ? ((mem_rdata >> sh) & msk) : mem_rdata;
  assign merged  = (mem_rdata & ~(msk << sh)) | ((wdata_q & msk) << sh);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      mem_valid  <= 1'b0;
      mem_write  <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      rsp_valid  <= 1'b0;
      rsp_status <= ST_OK;
      rsp_rdata  <= '0;
      lane_q     <= '0;
      half_q     <= 1'b0;
      sub_q      <= 1'b0;
      wdata_q    <= '0;
    end else begin
      mem_valid <= 1'b0;
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          lane_q  <= req_reg[1:0];
          half_q  <= (req_size == 3'd2);
          sub_q   <= sub;
          wdata_q <= req_wdata;
          if (!found) begin
            rsp_valid  <= 1'b1;
            rsp_status <= ST_NODEV;
            rsp_rdata  <= req_write ? 32'h0 : 32'hFFFF_FFFF;
          end else if (req_write && !size_ok) begin
            rsp_valid  <= 1'b1;
            rsp_status <= ST_BADREG;
            rsp_rdata  <= 32'h0;
          end else begin
            mem_valid <= 1'b1;
            mem_addr  <= tgt_addr;
            mem_write <= req_write && !sub;
            mem_wdata <= req_wdata;
            state     <= !req_write ? S_RD : (sub ? S_RMW : S_WR);
          end
        end
        S_RD: if (mem_rsp_valid) begin
          rsp_valid  <= 1'b1;
          rsp_status <= ST_OK;
          rsp_rdata  <= rd_lane;
          state      <= S_IDLE;
        end
        S_RMW: if (mem_rsp_valid) begin
          mem_valid <= 1'b1;
          mem_write <= 1'b1;
          mem_wdata <= merged;
          state     <= S_WR;
        end
        default: if (mem_rsp_valid) begin
          rsp_valid  <= 1'b1;
          rsp_status <= ST_OK;
          rsp_rdata  <= 32'h0;
          state      <= S_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/cfg_addr_gen_chk.sv
module cfg_addr_gen_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [7:0]        req_bus,
  input logic [4:0]        req_dev,
  input logic [2:0]        req_fn,
  input logic [9:0]        reg_hi,
  input logic [2:0]        req_size,
  input logic [ADDR_W-1:0] apt_base,
  input logic              mem_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              rsp_valid,
  input logic [1:0]        rsp_status
);

  logic acc, size_ok;
  assign acc     = req_valid && req_ready;
  assign size_ok = (req_size == 3'd1) || (req_size == 3'd2) || (req_size == 3'd4);

  logic [ADDR_W-1:0] exp_apt;
  always_ff @(posedge clk)
    exp_apt <= apt_base + ADDR_W'({reg_hi[9:6], req_bus, req_dev, req_fn, reg_hi[5:0], 2'b00});

  a_r8_busy_no_ready: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> !req_ready);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_valid |=> !mem_valid);

  a_r8_rsp_frees_front: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> req_ready);

  a_r7_bad_size: assert property (@(posedge clk) disable iff (rst)
    (acc && req_write && req_bus != 8'd0 && !size_ok) |=>
      (rsp_valid && rsp_status == 2'd2 && !mem_valid));

  a_r2_slot_zero: assert property (@(posedge clk) disable iff (rst)
    (acc && req_bus == 8'd0 && req_dev == 5'd0) |=>
      (rsp_valid && rsp_status == 2'd1 && !mem_valid));

  a_r3_apt_addr: assert property (@(posedge clk) disable iff (rst)
    (acc && req_bus != 8'd0 && (!req_write || size_ok)) |=>
      (mem_valid && mem_addr == exp_apt));

endmodule

bind cfg_addr_gen cfg_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .req_bus    (req_bus),
  .req_dev    (req_dev),
  .req_fn     (req_fn),
  .reg_hi     (req_reg[11:2]),
  .req_size   (req_size),
  .apt_base   (apt_base),
  .mem_valid  (mem_valid),
  .mem_addr   (mem_addr),
  .rsp_valid  (rsp_valid),
  .rsp_status (rsp_status)
);

// File: tb/tb_cfg_addr_gen.sv
module tb_cfg_addr_gen;
  localparam int AW = 32;
  localparam int NP = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst;
  logic [NP-1:0] port_en;
  logic [NP*AW-1:0] port_base;
  logic [AW-1:0] apt_base;
  logic          req_valid, req_ready, req_write;
  logic [7:0]    req_bus;
  logic [4:0]    req_dev;
  logic [2:0]    req_fn;
  logic [11:0]   req_reg;
  logic [2:0]    req_size;
  logic [31:0]   req_wdata;
  logic          rsp_valid;
  logic [1:0]    rsp_status;
  logic [31:0]   rsp_rdata;
  logic          mem_valid, mem_write;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic          mem_rsp_valid;
  logic [31:0]   mem_rdata;

  cfg_addr_gen #(.ADDR_W(AW), .NUM_PORTS(NP)) dut (.*);

  logic [31:0] base_cfg [NP];
  logic [NP-1:0] en_cfg;
  logic [31:0] apt_cfg;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  logic [31:0] mem_store [logic [31:0]];
  function automatic logic [31:0] peek(logic [31:0] a);
    if (mem_store.exists(a)) return mem_store[a];
    return a ^ 32'h5A3C_9F17;
  endfunction

  logic        mq_wr [$];
  logic [31:0] mq_addr [$];
  logic [31:0] mq_data [$];
  string       mq_tag [$];
  logic [1:0]  rq_st [$];
  logic [31:0] rq_data [$];
  string       rq_tag [$];

  bit          pend = 0;
  int          pcnt = 0;
  int          nops = 0;
  logic [31:0] rd_hold;

  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (pend) begin
      if (pcnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rdata = rd_hold;
        pend = 0;
      end else pcnt--;
    end
    if (!rst && mem_valid) begin
      pend = 1;
      pcnt = nops % 3;
      nops++;
      if (mem_write) mem_store[mem_addr] = mem_wdata;
      else rd_hold = peek(mem_addr);
    end
  end

  always @(negedge clk) begin
    if (!rst && mem_valid) begin
      if (mq_wr.size() == 0) check(0, "R8", "unexpected memory op", mem_addr, 32'h0);
      else begin
        logic e_wr; logic [31:0] e_a, e_d; string t;
        e_wr = mq_wr.pop_front(); e_a = mq_addr.pop_front();
        e_d = mq_data.pop_front(); t = mq_tag.pop_front();
        check(mem_write == e_wr, t, "mem_write", 32'(mem_write), 32'(e_wr));
        check(mem_addr == e_a, t, "mem_addr", mem_addr, e_a);
        if (e_wr) check(mem_wdata == e_d, t, "mem_wdata", mem_wdata, e_d);
      end
    end
    if (!rst && rsp_valid) begin
      if (rq_st.size() == 0) check(0, "R8", "unexpected response", rsp_rdata, 32'h0);
      else begin
        logic [1:0] e_s; logic [31:0] e_d; string t;
        e_s = rq_st.pop_front(); e_d = rq_data.pop_front(); t = rq_tag.pop_front();
        check(rsp_status == e_s, t, "rsp_status", 32'(rsp_status), 32'(e_s));
        check(rsp_rdata == e_d, t, "rsp_rdata", rsp_rdata, e_d);
      end
    end
  end

  task automatic push_mop(logic wr, logic [31:0] a, logic [31:0] d, string t);
    mq_wr.push_back(wr); mq_addr.push_back(a); mq_data.push_back(d); mq_tag.push_back(t);
  endtask
  task automatic push_rsp(logic [1:0] s, logic [31:0] d, string t);
    rq_st.push_back(s); rq_data.push_back(d); rq_tag.push_back(t);
  endtask

  task automatic do_req(bit wr, logic [7:0] bus, logic [4:0] dev, logic [2:0] fn,
                        logic [11:0] rg, logic [2:0] sz, logic [31:0] wd, string tag);
    logic [31:0] a, w, m;
    bit fnd, busy, szok;
    int sh;
    while (!req_ready) @(negedge clk);
    fnd = 1; a = 0;
    if (bus == 0) begin
      if (dev >= 1 && dev <= NP && en_cfg[dev-1]) a = base_cfg[dev-1] + (32'(rg) & 32'hFFC);
      else fnd = 0;
    end else begin
      a = apt_cfg + (((32'(rg) & 32'hF00) << 16) | (32'(bus) << 16) | (32'(dev) << 11) |
                     (32'(fn) << 8) | (32'(rg) & 32'hFC));
    end
    sh = 8 * int'(rg[1:0]);
    m = (sz == 3'd2) ? 32'hFFFF : 32'hFF;
    szok = (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
    busy = fnd && !(wr && !szok);
    if (!fnd) push_rsp(2'd1, wr ? 32'h0 : 32'hFFFF_FFFF, tag);
    else if (!wr) begin
      push_mop(0, a, 0, tag);
      w = peek(a);
      push_rsp(2'd0, (sz == 3'd1 || sz == 3'd2) ? ((w >> sh) & m) : w, tag);
    end else if (sz == 3'd4) begin
      push_mop(1, a, wd, tag);
      push_rsp(2'd0, 32'h0, tag);
    end else if (szok) begin
      w = peek(a);
      push_mop(0, a, 0, tag);
      push_mop(1, a, (w & ~(m << sh)) | ((wd & m) << sh), tag);
      push_rsp(2'd0, 32'h0, tag);
    end else push_rsp(2'd2, 32'h0, tag);
    req_valid = 1; req_write = wr; req_bus = bus; req_dev = dev; req_fn = fn;
    req_reg = rg; req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    check(req_ready == !busy, "R8", "req_ready after accept", 32'(req_ready), 32'(!busy));
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL R8 watchdog: actual cycles %0d expected fewer than %0d", cyc, 20000);
      summary();
    end
  end

  initial begin
    base_cfg[0] = 32'h0010_1000;
    base_cfg[1] = 32'h0020_2000;
    base_cfg[2] = 32'h0030_3000;
    en_cfg  = 3'b101;
    apt_cfg = 32'h4000_0000;
    port_en = en_cfg;
    port_base = {base_cfg[2], base_cfg[1], base_cfg[0]};
    apt_base = apt_cfg;
    mem_rsp_valid = 0; mem_rdata = 0;
    req_valid = 0; req_write = 0; req_bus = 0; req_dev = 0; req_fn = 0;
    req_reg = 0; req_size = 0; req_wdata = 0;
    rst = 1;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R9", "req_ready in reset", 32'(req_ready), 32'h1);
    check(mem_valid == 1'b0, "R9", "mem_valid in reset", 32'(mem_valid), 32'h0);
    check(rsp_valid == 1'b0, "R9", "rsp_valid in reset", 32'(rsp_valid), 32'h0);
    rst = 0;
    @(negedge clk);

    do_req(0, 8'd0, 5'd1, 3'd5, 12'h010, 3'd4, 0, "R1");
    do_req(0, 8'd0, 5'd3, 3'd0, 12'h107, 3'd4, 0, "R1");
    do_req(0, 8'd0, 5'd2, 3'd0, 12'h010, 3'd4, 0, "R2");
    do_req(0, 8'd0, 5'd0, 3'd0, 12'h000, 3'd4, 0, "R2");
    do_req(0, 8'd0, 5'd4, 3'd0, 12'h000, 3'd1, 0, "R2");
    do_req(1, 8'd0, 5'd2, 3'd0, 12'h004, 3'd4, 32'h1234_5678, "R2");
    do_req(0, 8'd5, 5'd31, 3'd7, 12'hA3C, 3'd4, 0, "R3");
    do_req(0, 8'd200, 5'd9, 3'd2, 12'hF41, 3'd1, 0, "R3");
    for (int l = 0; l < 4; l++) do_req(0, 8'd1, 5'd2, 3'd1, 12'h040 + 12'(l), 3'd1, 0, "R4");
    do_req(0, 8'd1, 5'd2, 3'd1, 12'h042, 3'd2, 0, "R4");
    do_req(0, 8'd1, 5'd2, 3'd1, 12'h040, 3'd2, 0, "R4");
    do_req(0, 8'd1, 5'd2, 3'd1, 12'h043, 3'd2, 0, "R4");
    do_req(0, 8'd1, 5'd2, 3'd1, 12'h041, 3'd3, 0, "R4");
    do_req(1, 8'd0, 5'd1, 3'd0, 12'h020, 3'd4, 32'hCAFE_F00D, "R5 R10");
    do_req(0, 8'd0, 5'd1, 3'd0, 12'h020, 3'd4, 0, "R5");
    do_req(1, 8'd3, 5'd4, 3'd0, 12'h083, 3'd1, 32'h0000_01A7, "R6 R10");
    do_req(0, 8'd3, 5'd4, 3'd0, 12'h080, 3'd4, 0, "R6");
    do_req(1, 8'd0, 5'd3, 3'd0, 12'h22A, 3'd2, 32'hFFFF_BEEF, "R6");
    do_req(0, 8'd0, 5'd3, 3'd0, 12'h228, 3'd4, 0, "R6");
    do_req(1, 8'd0, 5'd1, 3'd0, 12'h020, 3'd1, 32'h0000_0011, "R6");
    do_req(0, 8'd0, 5'd1, 3'd0, 12'h020, 3'd4, 0, "R6");
    do_req(1, 8'd2, 5'd1, 3'd0, 12'h010, 3'd0, 32'h1, "R7");
    do_req(1, 8'd2, 5'd1, 3'd0, 12'h010, 3'd3, 32'h1, "R7");
    do_req(1, 8'd0, 5'd1, 3'd0, 12'h010, 3'd5, 32'h1, "R7");
    do_req(0, 8'd2, 5'd1, 3'd0, 12'h010, 3'd4, 0, "R7");

    while (!req_ready || rq_st.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(mq_wr.size() == 0, "R8", "memory ops left", 32'(mq_wr.size()), 32'h0);
    check(rq_st.size() == 0, "R10", "responses left", 32'(rq_st.size()), 32'h0);
    done = 1;
    summary();
  end

endmodule